// File: doc/BRIEF.md
# Suspend Modulation Duty-Cycle Generator

This block throttles a processor core by driving its active-low suspend input. While modulation is enabled, the output alternates between a run phase and a suspend phase. In the run phase the output is high and the core executes. In the suspend phase the output is low and the core clock stops. Each phase lasts a programmed number of 32 µs ticks. The fraction of time the core runs is therefore the run count divided by the sum of the run and suspend counts.

A free-running prescaler derives the 32 µs tick from the block clock. A second prescaler derives a 1 ms tick for two speedup timers. An interrupt event or a video event can reload its timer. While either timer is non-zero, throttling pauses and the core runs at full speed.

Software programs the block through a byte-wide write port. The port carries the run count, the suspend count, a configuration byte, a power-management enable byte and the two speedup reload values.

Top module: `susp_mod_gen`

## Requirements
- R1: After reset, `susp_n` is 1 and every programmable value is 0.
- R2: While modulation runs, a run phase (`susp_n` = 1) lasts the byte at address 0x94 times one tick. A suspend phase (`susp_n` = 0) lasts the byte at address 0x95 times one tick. The two phases alternate, and the run phase comes first after idle.
- R3: Bit 0 of the configuration byte at address 0x96 enables modulation. While it is 0, `susp_n` is 1 from the cycle after the bit is seen.
- R4: A phase whose count is 0 is skipped and the other phase repeats. If both counts are 0, `susp_n` stays 1.
- R5: A count written while its phase is running does not change that phase. The new value is used at the next phase boundary.
- R6: With bit 0 (global) and bit 3 of the enable byte at 0x80 both set, an `irq_evt` pulse loads the interrupt timer from the byte at 0x8C, in units of 1 ms. While the timer is non-zero, `susp_n` is 1.
- R7: With bit 0 and bit 4 of the enable byte at 0x80 both set, a `vid_evt` pulse loads the video timer from the byte at 0x8D, in units of 1 ms. While that timer is non-zero, `susp_n` is 1.
- R8: Each new event reloads its timer to the full programmed value, even if the timer is still running.
- R9: An event is ignored if its speedup bit or the global bit is 0.
- R10: The tick is CLK_HZ/1,000,000 × 32 clock cycles long. The millisecond tick is CLK_HZ/1000 cycles long.
- R11: A write to any other address changes no programmable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| irq_evt | input | 1 | Interrupt activity pulse |
| vid_evt | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the interrupt and video speedup reloads. The bench pulses both events in one cycle with different reload values. It then checks that throttling stays paused until the longer of the two timers has drained.

The second pair is a count rewrite and a phase boundary. The bench writes new counts during a running suspend phase and lets the phase boundary arrive. A behavioural reference model is compared against `susp_n` on every clock, so any early pick-up of the new count or any early resume is reported.

// File: rtl/susp_pkg.sv
package susp_pkg;
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SUSP = 2'd2
    } phase_e;

    localparam logic [7:0] ADDR_RUN_CNT  = 8'h94;
    localparam logic [7:0] ADDR_SUSP_CNT = 8'h95;
    localparam logic [7:0] ADDR_CFG      = 8'h96;
    localparam logic [7:0] ADDR_PME      = 8'h80;
    localparam logic [7:0] ADDR_IRQ_TMR  = 8'h8C;
    localparam logic [7:0] ADDR_VID_TMR  = 8'h8D;
endpackage

// File: rtl/susp_prescaler.sv
module susp_prescaler #(
    parameter int DIV = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        tick = (st_q.cnt == LAST);
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: the counter restarts right after each tick
    a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));
endmodule

// File: rtl/susp_regs.sv
module susp_regs
    import susp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] run_cnt,
    output logic [DW-1:0] susp_cnt,
    output logic [DW-1:0] irq_reload,
    output logic [DW-1:0] vid_reload,
    output logic          mod_en,
    output logic          glob_en,
    output logic          irq_spd_en,
    output logic          vid_spd_en
);
    typedef struct packed {
        logic [DW-1:0] run_c;
        logic [DW-1:0] susp_c;
        logic [DW-1:0] irq_r;
        logic [DW-1:0] vid_r;
        logic          mod;
        logic          glob;
        logic          irq;
        logic          vid;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_RUN_CNT:  r_d.run_c  = wr_data;
                ADDR_SUSP_CNT: r_d.susp_c = wr_data;
                ADDR_IRQ_TMR:  r_d.irq_r  = wr_data;
                ADDR_VID_TMR:  r_d.vid_r  = wr_data;
                ADDR_CFG:      r_d.mod    = wr_data[0];
                ADDR_PME: begin
                    r_d.glob = wr_data[0];
                    r_d.irq  = wr_data[3];
                    r_d.vid  = wr_data[4];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign run_cnt    = r_q.run_c;
    assign susp_cnt   = r_q.susp_c;
    assign irq_reload = r_q.irq_r;
    assign vid_reload = r_q.vid_r;
    assign mod_en     = r_q.mod;
    assign glob_en    = r_q.glob;
    assign irq_spd_en = r_q.irq;
    assign vid_spd_en = r_q.vid;

    // R11: no write strobe, no change
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q));
endmodule

// File: rtl/susp_speedup.sv
module susp_speedup #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          arm,
    input  logic [TW-1:0] reload,
    input  logic          ms_tick,
    output logic          busy
);
    typedef struct packed {
        logic [TW-1:0] tmr;
    } spd_t;

    spd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt && arm)
            st_d.tmr = reload;
        else if (ms_tick && st_q.tmr != '0)
            st_d.tmr = st_q.tmr - 1'b1;
        busy = (st_q.tmr != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: an accepted event always loads the full reload value
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && arm) |=> (st_q.tmr == $past(reload)));
    // R6: without an event or a millisecond tick the timer holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt && arm) && !ms_tick) |=> $stable(st_q.tmr));
    // R9: an idle timer stays idle unless an event is accepted
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt && arm) && st_q.tmr == '0) |=> (st_q.tmr == '0));
endmodule

// File: rtl/susp_phase_fsm.sv
module susp_phase_fsm
    import susp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] run_cnt,
    input  logic [CW-1:0] susp_cnt,
    output logic          susp_n
);
    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;

    // Choose the next phase, preferring the one opposite to the current phase.
    function automatic fsm_t pick(phase_e from, logic [CW-1:0] rc, logic [CW-1:0] sc);
        fsm_t s;
        s.ph  = PH_IDLE;
        s.cnt = '0;
        if (from == PH_RUN) begin
            if (sc != '0)      begin s.ph = PH_SUSP; s.cnt = sc; end
            else if (rc != '0) begin s.ph = PH_RUN;  s.cnt = rc; end
        end else begin
            if (rc != '0)      begin s.ph = PH_RUN;  s.cnt = rc; end
            else if (sc != '0) begin s.ph = PH_SUSP; s.cnt = sc; end
        end
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else if (st_q.ph == PH_IDLE) begin
            st_d = pick(PH_IDLE, run_cnt, susp_cnt);
        end else if (tick) begin
            if (st_q.cnt == CW'(1)) st_d = pick(st_q.ph, run_cnt, susp_cnt);
            else                    st_d.cnt = st_q.cnt - 1'b1;
        end
        susp_n = (st_q.ph != PH_SUSP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: when modulation is stopped, the next cycle is idle
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.ph == PH_IDLE));
    // R4: a live phase never holds a zero count
    a_r4_live_count: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE) |-> (st_q.cnt != '0));
    // R5: between ticks a running phase keeps its state
    a_r5_keep_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && st_q.ph != PH_IDLE) |=> $stable(st_q));
endmodule

// File: rtl/susp_mod_gen.sv
module susp_mod_gen
    import susp_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_US = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       irq_evt,
    input  logic       vid_evt,
    output logic       susp_n
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int TICK_DIV   = CYC_PER_US * TICK_US;
    localparam int MS_DIV     = CLK_HZ / 1000;

    logic [CNT_W-1:0] run_cnt, susp_cnt, irq_reload, vid_reload;
    logic mod_en, glob_en, irq_spd_en, vid_spd_en;
    logic tick, ms_tick, irq_busy, vid_busy, run;

    susp_regs #(.DW(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .run_cnt(run_cnt), .susp_cnt(susp_cnt), .irq_reload(irq_reload),
        .vid_reload(vid_reload), .mod_en(mod_en), .glob_en(glob_en),
        .irq_spd_en(irq_spd_en), .vid_spd_en(vid_spd_en)
    );

    susp_prescaler #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));
    susp_prescaler #(.DIV(MS_DIV))   u_ms   (.clk(clk), .rst_n(rst_n), .tick(ms_tick));

    susp_speedup #(.TW(CNT_W)) u_irq_spd (
        .clk(clk), .rst_n(rst_n), .evt(irq_evt), .arm(glob_en && irq_spd_en),
        .reload(irq_reload), .ms_tick(ms_tick), .busy(irq_busy)
    );

    susp_speedup #(.TW(CNT_W)) u_vid_spd (
        .clk(clk), .rst_n(rst_n), .evt(vid_evt), .arm(glob_en && vid_spd_en),
        .reload(vid_reload), .ms_tick(ms_tick), .busy(vid_busy)
    );

    assign run = mod_en && !irq_busy && !vid_busy;

    susp_phase_fsm #(.CW(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .run_cnt(run_cnt), .susp_cnt(susp_cnt), .susp_n(susp_n)
    );

    // R3: modulation disabled keeps the core running
    a_r3_disabled_high: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> susp_n);
    // R6 / R7: a busy speedup timer keeps the core running
    a_r6_paused_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_busy || vid_busy) |=> susp_n);
endmodule

// File: tb/tb_susp_mod_gen.sv
module tb_susp_mod_gen;
    // Prescalers are scaled down through CLK_HZ so that milliseconds fit the run.
    localparam int CLK_HZ   = 1_000_000;
    localparam int TICK_DIV = (CLK_HZ / 1_000_000) * 32;  // R10
    localparam int MS_DIV   = CLK_HZ / 1000;              // R10

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic irq_evt = 1'b0;
    logic vid_evt = 1'b0;
    logic susp_n;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    susp_mod_gen #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq_evt(irq_evt), .vid_evt(vid_evt), .susp_n(susp_n)
    );

    // Behavioural reference model: phase 0 idle, 1 run, 2 suspend.
    int m_pre, m_ms, m_run, m_susp, m_itc, m_vtc, m_itmr, m_vtmr, m_ph, m_cnt;
    bit m_mod, m_glob, m_ien, m_ven;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_ms = 0; m_run = 0; m_susp = 0; m_itc = 0; m_vtc = 0;
            m_itmr = 0; m_vtmr = 0; m_ph = 0; m_cnt = 0;
            m_mod = 0; m_glob = 0; m_ien = 0; m_ven = 0;
        end else begin
            bit tk, mt, go;
            int np, nc;
            tk = (m_pre == TICK_DIV - 1);
            mt = (m_ms == MS_DIV - 1);
            go = m_mod && (m_itmr == 0) && (m_vtmr == 0);
            np = m_ph; nc = m_cnt;
            if (!go) begin
                np = 0; nc = 0;
            end else if (m_ph == 0 || (tk && m_cnt == 1)) begin
                if (m_ph == 1) begin
                    if (m_susp > 0)     begin np = 2; nc = m_susp; end
                    else if (m_run > 0) begin np = 1; nc = m_run; end
                    else                begin np = 0; nc = 0; end
                end else begin
                    if (m_run > 0)       begin np = 1; nc = m_run; end
                    else if (m_susp > 0) begin np = 2; nc = m_susp; end
                    else                 begin np = 0; nc = 0; end
                end
            end else if (tk) begin
                nc = m_cnt - 1;
            end
            m_ph = np; m_cnt = nc;
            if (irq_evt && m_glob && m_ien) m_itmr = m_itc;
            else if (mt && m_itmr > 0)      m_itmr = m_itmr - 1;
            if (vid_evt && m_glob && m_ven) m_vtmr = m_vtc;
            else if (mt && m_vtmr > 0)      m_vtmr = m_vtmr - 1;
            if (wr_en) begin
                case (wr_addr)
                    8'h94: m_run  = wr_data;
                    8'h95: m_susp = wr_data;
                    8'h8C: m_itc  = wr_data;
                    8'h8D: m_vtc  = wr_data;
                    8'h96: m_mod  = wr_data[0];
                    8'h80: begin m_glob = wr_data[0]; m_ien = wr_data[3]; m_ven = wr_data[4]; end
                    default: ;
                endcase
            end
            m_pre = tk ? 0 : m_pre + 1;
            m_ms  = mt ? 0 : m_ms + 1;
        end
    end

    // Cycle-by-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            bit exp;
            exp = (m_ph != 2);
            checks++;
            if (susp_n !== exp) begin
                fails++;
                $display("FAIL %s cycle compare: susp_n actual=%b expected=%b at %0t",
                         cur_req, susp_n, exp, $time);
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt(input bit irq, input bit vid);
        @(negedge clk);
        irq_evt = irq; vid_evt = vid;
        @(negedge clk);
        irq_evt = 1'b0; vid_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Length in cycles of the next complete stretch at the given level.
    task automatic run_len(input logic lvl, output int len);
        while (susp_n === lvl) @(negedge clk);
        while (susp_n !== lvl) @(negedge clk);
        len = 0;
        while (susp_n === lvl) begin len++; @(negedge clk); end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int len;
        idle(3);
        @(negedge clk);
        check("R1", "susp_n in reset", int'(susp_n), 1);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(5);
        check("R1", "susp_n after reset", int'(susp_n), 1);

        // R11: stray addresses must not enable modulation
        cur_req = "R11";
        wr(8'h94, 8'd3);
        wr(8'h95, 8'd2);
        wr(8'h97, 8'hFF);
        wr(8'h16, 8'hFF);
        idle(300);
        check("R11", "susp_n after stray writes", int'(susp_n), 1);

        // R2 / R10: run 3 ticks, suspend 2 ticks
        cur_req = "R2";
        wr(8'h96, 8'h01);
        run_len(1'b0, len);
        check("R2", "suspend stretch cycles", len, 2 * TICK_DIV);
        run_len(1'b1, len);
        check("R10", "run stretch cycles", len, 3 * TICK_DIV);

        // R5: rewrite counts in the middle of a suspend phase
        cur_req = "R5";
        while (susp_n !== 1'b0) @(negedge clk);
        idle(10);
        wr(8'h95, 8'd4);
        wr(8'h94, 8'd1);
        idle(400);
        run_len(1'b0, len);
        check("R5", "new suspend stretch", len, 4 * TICK_DIV);

        // R4: zero-count phases
        cur_req = "R4";
        wr(8'h94, 8'd0);
        wr(8'h95, 8'd3);
        idle(400);
        check("R4", "run count zero keeps suspend", int'(susp_n), 0);
        wr(8'h95, 8'd0);
        wr(8'h94, 8'd2);
        idle(300);
        check("R4", "suspend count zero keeps run", int'(susp_n), 1);
        wr(8'h94, 8'd0);
        idle(300);
        check("R4", "both zero keeps run", int'(susp_n), 1);

        // R6: interrupt speedup, 2 ms
        cur_req = "R6";
        wr(8'h94, 8'd2);
        wr(8'h95, 8'd2);
        wr(8'h8C, 8'd2);
        wr(8'h80, 8'h09);
        idle(200);
        pulse_evt(1'b1, 1'b0);
        idle(800);
        check("R6", "paused after irq", int'(susp_n), 1);
        idle(2500);

        // R8: a second event restarts the timer
        cur_req = "R8";
        pulse_evt(1'b1, 1'b0);
        idle(1000);
        pulse_evt(1'b1, 1'b0);
        idle(1500);
        check("R8", "still paused after reload", int'(susp_n), 1);
        idle(1500);

        // R7: video speedup, 3 ms
        cur_req = "R7";
        wr(8'h8D, 8'd3);
        wr(8'h80, 8'h11);
        pulse_evt(1'b0, 1'b1);
        idle(2500);
        check("R7", "paused after video event", int'(susp_n), 1);
        idle(2000);

        // R9: events ignored without their enables
        cur_req = "R9";
        wr(8'h80, 8'h08);
        while (susp_n !== 1'b0) @(negedge clk);
        pulse_evt(1'b1, 1'b1);
        idle(2);
        check("R9", "no pause without global bit", int'(susp_n), 0);
        wr(8'h80, 8'h01);
        idle(500);
        pulse_evt(1'b1, 1'b1);
        idle(1500);

        // R6 / R7 together: both events in one cycle
        cur_req = "R6";
        wr(8'h8C, 8'd1);
        wr(8'h8D, 8'd2);
        wr(8'h80, 8'h19);
        pulse_evt(1'b1, 1'b1);
        idle(1500);
        check("R7", "longer timer still pauses", int'(susp_n), 1);
        idle(2000);

        // R3: disabling modulation
        cur_req = "R3";
        while (susp_n !== 1'b0) @(negedge clk);
        wr(8'h96, 8'h00);
        idle(1);
        check("R3", "disabled output", int'(susp_n), 1);
        idle(400);

        cmp_on = 1'b0;
        finish_run();
    end
endmodule